// File: doc/BRIEF.md
# Shared Interrupt Controller with Context Routing

This block collects a parameterised set of shared interrupt sources and delivers them to a small number of processor contexts. Each source has its own polarity (active-high or active-low), its own trigger mode (level or edge) and its own enable bit. It also has a routing entry and a context bitmap. The routing entry holds a pin index, a "routed" bit and an NMI bit. The context bitmap picks the contexts that receive the source. Each context gets one ordinary interrupt line and one NMI line, both registered.

Software drives the block through a plain single-cycle register port. Enable bits are changed through two write-only banks, one that sets bits and one that clears them, so no read-modify-write is needed. A write-only "strike" register sets or clears the edge latch of one source, chosen by number. This is how inter-processor interrupts are raised and how edge interrupts are acknowledged. Per-context "winner" registers return the lowest-numbered source that is being delivered to that context. A read-only identity word reports how many sources and contexts the block has.

No interface of this block carries a data stream, so it has no valid/ready handshake. The register port has no back-pressure. Every write is applied at the clock edge on which it is presented. A read returns its data with `rvalid` one cycle later. Requests may be issued on every cycle.

Top module: `shint_ctrl`

## Requirements
- R1: After reset, every polarity bit, trigger bit, enable bit, edge latch, routing entry and context bitmap is zero. `irq_o`, `nmi_o` and `rvalid` are low, and every winner register reads 0xFFFFFFFF.
- R2: A write to the set bank (offset 0x010+w) sets the enable of source 32w+b for each 1 in bit b of the data. A write to the clear bank (offset 0x018+w) clears it. Zero bits leave the enable unchanged. The enable bitmap reads back at 0x028+w.
- R3: The polarity bitmap (0x030+w, 1 = active-low) and the trigger bitmap (0x038+w, 1 = edge) can be read and written. A level source is pending while its input XOR its polarity bit is 1. The pending bitmap reads at 0x020+w.
- R4: An edge source's latch is set when its polarity-adjusted input goes from 0 to 1. The latch then holds after the input returns, until a strike clear. While a source is in level mode, its latch stays clear.
- R5: A write to the strike register (0x001) acts on the source numbered by bits [7:0]. It sets that source's latch if bit 31 is 1 and clears it if bit 31 is 0. Strikes on consecutive cycles each take effect. A strike has no effect on a level source or on a number not below NSRC.
- R6: `irq_o[c]` is high one cycle after the following holds for some source: pending, enabled, routed bit 31 = 1, NMI bit 30 = 0, and context bit c set. The routing entry (0x100+n: bit 31 routed, bit 30 NMI, bits [5:0] pin) and the context bitmap (0x200+n) read back what was written.
- R7: A source with NMI bit 30 set drives `nmi_o[c]` instead of `irq_o[c]`, for every context c in its bitmap, whether or not it is routed. A source with neither bit set is never delivered.
- R8: The winner register of context c (0x040+c) returns the lowest source number delivered to c on either line, or 0xFFFFFFFF when none is.
- R9: The identity word (0x000) reads {8'h0, NSRC/8−1, 8'h0, NCTX−1} and ignores writes. With the defaults it reads 0x00030003.
- R10: `rvalid` is high exactly one cycle after `rd_en`. The data reflects every write presented in earlier cycles. Write-only and unused offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Interrupt source inputs, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 10 | Register word address |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| rdata | output | 32 | Read data |
| irq_o | output | NCTX | Ordinary interrupt line per context |
| nmi_o | output | NCTX | NMI line per context |

## Verification
The assertions assume three things about the inputs: `src_i` is already synchronous to `clk`, `rd_en` and `wr_en` are never X after reset, and a strike write carries one source number. The stimulus drives every input one nanosecond after a rising edge and starts from a held reset. Strike numbers are drawn from a range that deliberately exceeds NSRC, so the ignore path is exercised while each write still names one source. A reference model in the bench tracks the edge history of the inputs cycle by cycle. Random source toggles therefore exercise polarity changes and trigger-mode switches in the middle of an edge, without any further constraint.

// File: rtl/shint_pkg.sv
package shint_pkg;
  localparam int ADDR_W = 10;
  localparam int PIN_W  = 6;
  localparam int STRIKE_SET_BIT = 31;

  localparam logic [1:0] RG_GLB = 2'd0;
  localparam logic [1:0] RG_PIN = 2'd1;
  localparam logic [1:0] RG_CTX = 2'd2;

  localparam logic [7:0] OFS_ID     = 8'h00;
  localparam logic [7:0] OFS_STRIKE = 8'h01;

  localparam logic [4:0] PG_ID    = 5'h00;
  localparam logic [4:0] PG_SET   = 5'h02;
  localparam logic [4:0] PG_CLR   = 5'h03;
  localparam logic [4:0] PG_PEND  = 5'h04;
  localparam logic [4:0] PG_EN    = 5'h05;
  localparam logic [4:0] PG_POL   = 5'h06;
  localparam logic [4:0] PG_TRIG  = 5'h07;
  localparam logic [4:0] PG_WIN   = 5'h08;

  typedef struct packed {
    logic             routed;
    logic             nmi;
    logic [PIN_W-1:0] pin;
  } route_t;
endpackage

// File: rtl/shint_src.sv
module shint_src (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic pol_low,
  input  logic trig_edge,
  input  logic strike_set,
  input  logic strike_clr,
  output logic pend_o
);
  logic act, prev, latch;

  assign act    = src_i ^ pol_low;
  assign pend_o = trig_edge ? latch : act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev  <= 1'b0;
      latch <= 1'b0;
    end else begin
      prev  <= act;
      if (trig_edge) latch <= (latch & ~strike_clr) | strike_set | (act & ~prev);
      else           latch <= 1'b0;
    end
  end

  // R5: a strike set on an edge source is pending on the next cycle
  a_r5_strike_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_edge && strike_set) |=> latch);
  // R4: an edge latch holds unless struck clear
  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_edge && latch && !strike_clr) |=> latch);
  // R4: level mode keeps the latch clear
  a_r4_level_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_edge |=> !latch);
endmodule

// File: rtl/shint_lowest.sv
module shint_lowest #(
  parameter int N = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  // R8: the reported index is set and nothing below it is
  a_r8_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (vec[idx] && ((vec & ((N'(1) << idx) - N'(1))) == '0)));
  a_r8_none: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (vec == '0));
endmodule

// File: rtl/shint_ctrl.sv
module shint_ctrl
  import shint_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int NCTX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  output logic              rvalid,
  output logic [31:0]       rdata,
  output logic [NCTX-1:0]   irq_o,
  output logic [NCTX-1:0]   nmi_o
);
  localparam int NW = NSRC / 32;
  localparam int IW = $clog2(NSRC);
  localparam logic [31:0] ID_WORD = {8'h00, 8'(NSRC / 8 - 1), 8'h00, 8'(NCTX - 1)};

  logic [NSRC-1:0] pol_low, trig_edge, en, pend, sset, sclr;
  route_t          route [NSRC];
  logic [NCTX-1:0] ctx_map [NSRC];
  logic [NCTX-1:0] irq_d, nmi_d;
  logic            win_found [NCTX];
  logic [IW-1:0]   win_idx   [NCTX];

  logic [1:0] rsel;
  logic [7:0] ofs;
  logic       glb_wr, idx_ok;
  assign rsel   = addr[9:8];
  assign ofs    = addr[7:0];
  assign glb_wr = wr_en && (rsel == RG_GLB);
  assign idx_ok = int'(ofs) < NSRC;

  // strike decode: one source per write
  always_comb begin
    sset = '0;
    sclr = '0;
    if (glb_wr && ofs == OFS_STRIKE && int'(wdata[7:0]) < NSRC) begin
      if (wdata[STRIKE_SET_BIT]) sset[wdata[IW-1:0]] = 1'b1;
      else                       sclr[wdata[IW-1:0]] = 1'b1;
    end
  end

  // bitmap banks, 32 sources per word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_low   <= '0;
      trig_edge <= '0;
      en        <= '0;
    end else if (glb_wr) begin
      for (int w = 0; w < NW; w++) begin
        if (ofs[2:0] == 3'(w)) begin
          case (ofs[7:3])
            PG_SET:  en[w*32 +: 32]        <= en[w*32 +: 32] | wdata;
            PG_CLR:  en[w*32 +: 32]        <= en[w*32 +: 32] & ~wdata;
            PG_POL:  pol_low[w*32 +: 32]   <= wdata;
            PG_TRIG: trig_edge[w*32 +: 32] <= wdata;
            default: ;
          endcase
        end
      end
    end
  end

  // per-source routing entries
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) begin
        route[s]   <= '0;
        ctx_map[s] <= '0;
      end
    end else if (wr_en && idx_ok) begin
      if (rsel == RG_PIN)
        route[ofs[IW-1:0]] <= '{routed: wdata[31], nmi: wdata[30], pin: wdata[PIN_W-1:0]};
      if (rsel == RG_CTX)
        ctx_map[ofs[IW-1:0]] <= wdata[NCTX-1:0];
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    shint_src u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_i[s]),
      .pol_low    (pol_low[s]),
      .trig_edge  (trig_edge[s]),
      .strike_set (sset[s]),
      .strike_clr (sclr[s]),
      .pend_o     (pend[s])
    );
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [NSRC-1:0] d_irq, d_nmi;
    always_comb begin
      for (int s = 0; s < NSRC; s++) begin
        d_irq[s] = pend[s] & en[s] & ctx_map[s][c] & route[s].routed & ~route[s].nmi;
        d_nmi[s] = pend[s] & en[s] & ctx_map[s][c] & route[s].nmi;
      end
    end
    assign irq_d[c] = |d_irq;
    assign nmi_d[c] = |d_nmi;
    shint_lowest #(.N(NSRC)) u_low (
      .clk   (clk),
      .rst_n (rst_n),
      .vec   (d_irq | d_nmi),
      .found (win_found[c]),
      .idx   (win_idx[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= '0;
      nmi_o <= '0;
    end else begin
      irq_o <= irq_d;
      nmi_o <= nmi_d;
    end
  end

  // read mux
  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    case (rsel)
      RG_GLB: begin
        for (int w = 0; w < NW; w++) begin
          if (ofs[2:0] == 3'(w)) begin
            case (ofs[7:3])
              PG_PEND: rd_word = pend[w*32 +: 32];
              PG_EN:   rd_word = en[w*32 +: 32];
              PG_POL:  rd_word = pol_low[w*32 +: 32];
              PG_TRIG: rd_word = trig_edge[w*32 +: 32];
              default: ;
            endcase
          end
        end
        if (ofs == OFS_ID) rd_word = ID_WORD;
        if (ofs[7:3] == PG_WIN) begin
          for (int c = 0; c < NCTX; c++)
            if (ofs[2:0] == 3'(c)) rd_word = win_found[c] ? 32'(win_idx[c]) : '1;
        end
      end
      RG_PIN: if (idx_ok) rd_word = {route[ofs[IW-1:0]].routed, route[ofs[IW-1:0]].nmi,
                                     {(30 - PIN_W){1'b0}}, route[ofs[IW-1:0]].pin};
      RG_CTX: if (idx_ok) rd_word = 32'(ctx_map[ofs[IW-1:0]]);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

  // R2: clear bank removes every written bit of word 0
  a_r2_clear_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == {RG_GLB, PG_CLR, 3'd0}) |=> ((en[31:0] & $past(wdata)) == '0));
  // R2: set bank enables every written bit of word 0
  a_r2_set_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == {RG_GLB, PG_SET, 3'd0}) |=> ((en[31:0] & $past(wdata)) == $past(wdata)));
  // R6, R7: nothing enabled means both lines low next cycle
  a_r6_silent_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> (irq_o == '0 && nmi_o == '0));
  // R10: read valid tracks the strobe by one cycle
  a_r10_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  a_r10_rvalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  // R9: identity word is constant
  a_r9_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == {RG_GLB, OFS_ID}) |=> (rdata == ID_WORD));
endmodule

// File: tb/shint_ctrl_tb.sv
module shint_ctrl_tb;
  localparam int NS = 32;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic          rvalid;
  logic [31:0]   rdata;
  logic [NC-1:0] irq_o, nmi_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shint_ctrl #(.NSRC(NS), .NCTX(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_en(rd_en), .rvalid(rvalid), .rdata(rdata),
    .irq_o(irq_o), .nmi_o(nmi_o));

  // reference model state
  logic [NS-1:0] m_pol, m_trig, m_en, m_latch, m_prev, m_routed, m_nmi;
  logic [5:0]    m_pin [NS];
  logic [NC-1:0] m_ctx [NS];
  string         rd_label;

  function automatic void model_reset();
    m_pol = '0; m_trig = '0; m_en = '0; m_latch = '0; m_prev = '0;
    m_routed = '0; m_nmi = '0;
    for (int s = 0; s < NS; s++) begin m_pin[s] = '0; m_ctx[s] = '0; end
  endfunction

  function automatic logic [NS-1:0] deliv(int c, logic [NS-1:0] pend, bit want_nmi);
    logic [NS-1:0] r;
    for (int s = 0; s < NS; s++)
      r[s] = pend[s] & m_en[s] & m_ctx[s][c] & (want_nmi ? m_nmi[s] : (m_routed[s] & ~m_nmi[s]));
    return r;
  endfunction

  function automatic logic [31:0] mread(logic [9:0] a, logic [NS-1:0] pend);
    logic [7:0] o = a[7:0];
    logic [NS-1:0] v;
    if (a[9:8] == 2'd1) return (o < NS) ? {m_routed[o], m_nmi[o], 24'h0, m_pin[o]} : 32'h0;
    if (a[9:8] == 2'd2) return (o < NS) ? 32'(m_ctx[o]) : 32'h0;
    if (a[9:8] != 2'd0) return 32'h0;
    case (o)
      8'h00: return 32'h0003_0003;
      8'h20: return pend;
      8'h28: return m_en;
      8'h30: return m_pol;
      8'h38: return m_trig;
      default: ;
    endcase
    if (o >= 8'h40 && o < 8'h40 + NC) begin
      v = deliv(int'(o - 8'h40), pend, 0) | deliv(int'(o - 8'h40), pend, 1);
      for (int s = 0; s < NS; s++) if (v[s]) return 32'(s);
      return 32'hFFFF_FFFF;
    end
    return 32'h0;
  endfunction

  function automatic string req_of(logic [9:0] a);
    if (a[9:8] != 2'd0) return "R6";
    case (a[7:0])
      8'h00: return "R9";
      8'h20, 8'h30, 8'h38: return "R3";
      8'h28: return "R2";
      default: return (a[7:0] >= 8'h40) ? "R8" : "R10";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: model follows the same edge as the design
  task automatic tick();
    logic [NS-1:0] act, pend, ss, sc, nl;
    logic [NC-1:0] ei, en_;
    logic [31:0]   erd;
    logic          do_rd = rd_en;
    act  = src ^ m_pol;
    pend = (m_trig & m_latch) | (~m_trig & act);
    for (int c = 0; c < NC; c++) begin
      ei[c]  = |deliv(c, pend, 0);
      en_[c] = |deliv(c, pend, 1);
    end
    erd = mread(addr, pend);
    ss = '0; sc = '0;
    if (wr_en && addr == 10'h001 && wdata[7:0] < NS) begin
      if (wdata[31]) ss[wdata[4:0]] = 1'b1; else sc[wdata[4:0]] = 1'b1;
    end
    nl = m_trig & ((m_latch & ~sc) | ss | (act & ~m_prev));
    m_prev = act; m_latch = nl;
    if (wr_en) begin
      if (addr[9:8] == 2'd1 && addr[7:0] < NS) begin
        m_routed[addr[4:0]] = wdata[31]; m_nmi[addr[4:0]] = wdata[30]; m_pin[addr[4:0]] = wdata[5:0];
      end else if (addr[9:8] == 2'd2 && addr[7:0] < NS) begin
        m_ctx[addr[4:0]] = wdata[NC-1:0];
      end else if (addr[9:8] == 2'd0) begin
        case (addr[7:0])
          8'h10: m_en = m_en | wdata;
          8'h18: m_en = m_en & ~wdata;
          8'h30: m_pol = wdata;
          8'h38: m_trig = wdata;
          default: ;
        endcase
      end
    end
    @(posedge clk); #1;
    check("R6/R7 lines", {24'h0, irq_o, nmi_o}, {24'h0, ei, en_});
    if (do_rd) begin
      check("R10 rvalid", 32'(rvalid), 32'd1);
      check(rd_label, rdata, erd);
    end else check("R10 rvalid idle", 32'(rvalid), 32'd0);
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d; tick(); wr_en = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, string lbl);
    rd_en = 1'b1; addr = a; rd_label = lbl; tick(); rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset values
    rd(10'h028, "R1 enables");
    rd(10'h030, "R1 polarity");
    rd(10'h038, "R1 trigger");
    rd(10'h020, "R1 pending");
    rd(10'h040, "R1 winner");
    rd(10'h105, "R1 route");
    // R9: identity and write ignore
    rd(10'h000, "R9 identity");
    wr(10'h000, 32'hFFFF_FFFF);
    rd(10'h000, "R9 identity after write");
    // R6: level source 0 to context 0
    wr(10'h100, 32'h8000_0002);
    wr(10'h200, 32'h1);
    wr(10'h010, 32'h0000_0001);
    src[0] = 1'b1; tick(); tick();
    rd(10'h040, "R8 single winner");
    rd(10'h100, "R6 route readback");
    // R3: invert polarity of source 0
    wr(10'h030, 32'h1);
    rd(10'h020, "R3 active-low pending");
    // R4: edge source 5 to context 1
    wr(10'h105, 32'h8000_0000);
    wr(10'h205, 32'h2);
    wr(10'h038, 32'h0000_00A0);
    wr(10'h010, 32'h0000_00A0);
    src[5] = 1'b1; tick(); src[5] = 1'b0; tick(); tick();
    rd(10'h020, "R4 latch holds");
    // R5: strike clear then back-to-back sets
    wr(10'h001, 32'h0000_0005);
    rd(10'h020, "R5 strike clear");
    wr(10'h107, 32'h8000_0000);
    wr(10'h207, 32'h2);
    wr(10'h001, 32'h8000_0007);
    wr(10'h001, 32'h8000_0005);
    rd(10'h020, "R5 consecutive strikes");
    rd(10'h041, "R8 lowest of two");
    // R5: ignored on level source and out of range
    src[0] = 1'b1;
    wr(10'h001, 32'h8000_0000);
    rd(10'h020, "R5 level strike ignored");
    wr(10'h001, 32'h8000_0028);
    rd(10'h020, "R5 out-of-range ignored");
    // R7: NMI to all contexts, unrouted source silent
    wr(10'h109, 32'h4000_0000);
    wr(10'h209, 32'hF);
    wr(10'h20A, 32'hF);
    wr(10'h010, 32'h0000_0600);
    src[9] = 1'b1; src[10] = 1'b1; tick(); tick();
    rd(10'h043, "R7 nmi winner");
    // R2: clear bank
    wr(10'h018, 32'hFFFF_FFFF);
    rd(10'h028, "R2 all cleared");
    tick();
    // random phase
    for (int i = 0; i < 600; i++) begin
      int op = $urandom % 12;
      src = src ^ ($urandom & $urandom & $urandom);
      case (op)
        0: wr(10'h010, $urandom);
        1: wr(10'h018, $urandom & $urandom);
        2: wr(10'h030, $urandom);
        3: wr(10'h038, $urandom);
        4, 5: wr(10'h001, {$urandom % 2 == 0, 23'h0, 8'($urandom % 48)});
        6: wr({2'd1, 8'($urandom % NS)}, $urandom);
        7: wr({2'd2, 8'($urandom % NS)}, $urandom);
        8, 9: begin
          logic [9:0] a;
          case ($urandom % 6)
            0: a = 10'h020; 1: a = 10'h028; 2: a = 10'h030;
            3: a = 10'h038; 4: a = {2'd1, 8'($urandom % NS)};
            default: a = {2'd0, 8'h40 + 8'($urandom % NC)};
          endcase
          rd(a, req_of(a));
        end
        default: tick();
      endcase
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule